// File: doc/BRIEF.md
# Motion-Adaptive Edge-Directed Field Deinterlacer

This block rebuilds the lines that an interlaced field lacks, one pixel per accepted beat. Each beat carries eight co-sited samples: luma and chroma from the field line directly above the missing line, the same from the field line directly below, and luma and chroma at the missing position from the opposite-parity field before and after the current one. The frame store ahead of the block aligns these streams and qualifies them with one valid strobe plus line-start and frame-start flags.

A motion test runs on every pixel. A pixel whose two temporal neighbours agree is woven from them. Otherwise it is interpolated inside the current field along whichever of three directions (left diagonal, vertical, right diagonal) best matches the lines above and below. The weave-or-interpolate choice made on luma also governs that pixel's chroma. The output pairs each pixel of the upper field line (the original lane) with the rebuilt pixel under it (the fill lane), so a downstream raster writer can emit the two lines in turn. For progressive sources a bypass mode, captured at each frame start, puts the lower line on the fill lane unchanged.

A sequencer tracks the position within a line. It has four states. ST_IDLE waits for the first frame start after reset. ST_LINE accepts pixels. ST_FLUSH is one cycle that emits the last pixel of a line. ST_GAP waits between lines. The transitions are:
- frame-open: ST_IDLE to ST_LINE, on a pixel carrying frame-start.
- line-end: ST_LINE to ST_FLUSH, on pixel WIDTH-1.
- line-open: ST_FLUSH or ST_GAP to ST_LINE, on a pixel carrying line-start or frame-start.
- rest: ST_FLUSH to ST_GAP, when no such pixel arrives.

Top module: `deint_core`

## Requirements
- R1: After reset, every pixel is ignored until one arrives with `in_sof` high. This holds even when `in_sol` is high. No output is produced for the ignored pixels.
- R2: A pixel is moving when |prev_y − next_y| is strictly greater than `cfg_motion_thr`. A difference equal to the threshold counts as static. `out_moving` reports the decision, and is 0 in bypass.
- R3: A static pixel's fill luma is (prev_y + next_y + 1) >> 1.
- R4: A moving pixel's fill luma is built from three candidate pairs:
  - negative: upper[x−1] with lower[x+1];
  - vertical: upper[x] with lower[x];
  - positive: upper[x+1] with lower[x−1].

  The pair with the smallest absolute difference wins. Vertical wins any tie it is part of, and negative wins a tie against positive. The result is the rounded mean (a + b + 1) >> 1 of the winning pair.
- R5: At x = 0 a missing x−1 neighbour is replaced by the sample at x. At x = WIDTH−1 a missing x+1 neighbour is replaced the same way.
- R6: Fill chroma follows the luma decision. A moving pixel gets (up_c + dn_c + 1) >> 1. A static pixel gets (prev_c + next_c + 1) >> 1.
- R7: The original lane carries the upper-line luma and chroma of the same pixel, unchanged.
- R8: `cfg_bypass` is sampled only on a pixel that opens a frame. In bypass, the fill lane carries the lower-line luma and chroma unchanged. A change of `cfg_bypass` in mid-frame has no effect until the next frame start.
- R9: Each line yields exactly WIDTH outputs, in pixel order. The output for pixel x appears in the cycle after pixel x+1 is accepted. The output for pixel WIDTH−1 appears two cycles after its own acceptance, with no further input needed.
- R10: `out_sol` is high on the output for x = 0. `out_sof` is high only on the x = 0 output of the line that opened the frame.
- R11: Between lines, pixels without `in_sol` or `in_sof` are ignored and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bypass | input | 1 | Progressive pass-through request, taken at frame start |
| cfg_motion_thr | input | PIX_W | Motion threshold |
| in_valid | input | 1 | Input beat qualifier |
| in_sol | input | 1 | Beat is pixel 0 of a line |
| in_sof | input | 1 | Beat is pixel 0 of a frame's first line |
| in_up_y | input | PIX_W | Luma, field line above |
| in_up_c | input | PIX_W | Chroma, field line above |
| in_dn_y | input | PIX_W | Luma, field line below |
| in_dn_c | input | PIX_W | Chroma, field line below |
| in_prv_y | input | PIX_W | Luma, previous opposite field |
| in_prv_c | input | PIX_W | Chroma, previous opposite field |
| in_nxt_y | input | PIX_W | Luma, next opposite field |
| in_nxt_c | input | PIX_W | Chroma, next opposite field |
| out_valid | output | 1 | Output beat qualifier |
| out_sol | output | 1 | Output is pixel 0 of a line |
| out_sof | output | 1 | Output is pixel 0 of a frame |
| out_moving | output | 1 | Motion decision for this pixel |
| out_orig_y | output | PIX_W | Original-lane luma |
| out_orig_c | output | PIX_W | Original-lane chroma |
| out_fill_y | output | PIX_W | Rebuilt luma |
| out_fill_c | output | PIX_W | Rebuilt chroma |

## Verification
A sequencer that loses its place in a line would show on the very next output. Such an output either lands on the wrong beat relative to the next accepted pixel, or breaks the exact WIDTH-per-line count. It could also raise `out_sol` on a pixel other than x = 0, or use the live input instead of the edge sample at the right border. A window register that misses a shift would put the wrong neighbour into the directional search. That shows within one pixel as a fill value that differs from the rounded mean the requirements predict, most visibly on diagonal edges and on tie patterns. A stale mode register would leak lower-line samples into the fill lane of an interlaced frame from its first pixel onward, or keep producing them after a frame start that turned bypass off.

// File: rtl/deint_pkg.sv
package deint_pkg;

    // Line sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;

    // Winning interpolation direction
    typedef enum logic [1:0] {
        DIR_VERT = 2'd0,
        DIR_NEG  = 2'd1,
        DIR_POS  = 2'd2
    } dir_t;

endpackage

// File: rtl/deint_seq.sv
module deint_seq
    import deint_pkg::*;
#(
    parameter int unsigned WIDTH = 720      // pixels per line, at least 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sol,
    input  logic       in_sof,
    output seq_state_t state_o,
    output logic       start_o,   // beat opens a new line
    output logic       shift_o,   // beat continues the current line
    output logic       emit_o,    // a centre pixel is produced this cycle
    output logic       flush_o    // right neighbour is missing
);

    localparam int unsigned CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_X = CW'(WIDTH - 1);

    seq_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic           line_tag;

    assign line_tag = in_valid && (in_sol || in_sof);
    assign state_o  = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        shift_o = 1'b0;
        emit_o  = 1'b0;
        flush_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    start_o = 1'b1;
                    state_d = ST_LINE;
                end
            end
            ST_LINE: begin
                if (in_valid) begin
                    shift_o = 1'b1;
                    emit_o  = 1'b1;
                    if (cnt_q == LAST_X) state_d = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                emit_o  = 1'b1;
                flush_o = 1'b1;
                if (line_tag) begin
                    start_o = 1'b1;
                    state_d = ST_LINE;
                end else begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (line_tag) begin
                    start_o = 1'b1;
                    state_d = ST_LINE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Index of the next pixel expected on the line
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (start_o) cnt_q <= CW'(1);
        else if (shift_o) cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/deint_dirsel.sv
module deint_dirsel
    import deint_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic [PIX_W-1:0] up_l,
    input  logic [PIX_W-1:0] up_c,
    input  logic [PIX_W-1:0] up_r,
    input  logic [PIX_W-1:0] dn_l,
    input  logic [PIX_W-1:0] dn_c,
    input  logic [PIX_W-1:0] dn_r,
    output logic [PIX_W-1:0] spat_o,
    output dir_t             dir_o
);

    localparam int unsigned NCAND = 3;
    localparam int unsigned SW    = PIX_W + 1;

    logic [PIX_W-1:0] pa [NCAND];
    logic [PIX_W-1:0] pb [NCAND];
    logic [PIX_W-1:0] dif [NCAND];
    logic [PIX_W-1:0] mean [NCAND];

    // candidate 0 vertical, 1 negative, 2 positive
    assign pa[0] = up_c;  assign pb[0] = dn_c;
    assign pa[1] = up_l;  assign pb[1] = dn_r;
    assign pa[2] = up_r;  assign pb[2] = dn_l;

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        logic [SW-1:0] sum;
        assign dif[k]  = (pa[k] > pb[k]) ? (pa[k] - pb[k]) : (pb[k] - pa[k]);
        assign sum     = SW'(pa[k]) + SW'(pb[k]) + SW'(1);
        assign mean[k] = sum[SW-1:1];
    end

    always_comb begin
        if (dif[0] <= dif[1] && dif[0] <= dif[2]) begin
            dir_o  = DIR_VERT;
            spat_o = mean[0];
        end else if (dif[1] <= dif[2]) begin
            dir_o  = DIR_NEG;
            spat_o = mean[1];
        end else begin
            dir_o  = DIR_POS;
            spat_o = mean[2];
        end
    end

endmodule

// File: rtl/deint_blend.sv
module deint_blend #(
    parameter int unsigned PIX_W = 8
) (
    input  logic             bypass,
    input  logic [PIX_W-1:0] thr,
    input  logic [PIX_W-1:0] spat_y,
    input  logic [PIX_W-1:0] dn_y,
    input  logic [PIX_W-1:0] prv_y,
    input  logic [PIX_W-1:0] nxt_y,
    input  logic [PIX_W-1:0] up_c,
    input  logic [PIX_W-1:0] dn_c,
    input  logic [PIX_W-1:0] prv_c,
    input  logic [PIX_W-1:0] nxt_c,
    output logic [PIX_W-1:0] fill_y,
    output logic [PIX_W-1:0] fill_c,
    output logic             moving
);

    localparam int unsigned SW = PIX_W + 1;

    function automatic logic [PIX_W-1:0] rmean(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
        logic [SW-1:0] s;
        s = SW'(a) + SW'(b) + SW'(1);
        return s[SW-1:1];
    endfunction

    logic [PIX_W-1:0] tdiff;

    assign tdiff  = (prv_y > nxt_y) ? (prv_y - nxt_y) : (nxt_y - prv_y);
    assign moving = !bypass && (tdiff > thr);

    always_comb begin
        if (bypass) begin
            fill_y = dn_y;
            fill_c = dn_c;
        end else if (moving) begin
            fill_y = spat_y;
            fill_c = rmean(up_c, dn_c);
        end else begin
            fill_y = rmean(prv_y, nxt_y);
            fill_c = rmean(prv_c, nxt_c);
        end
    end

endmodule

// File: rtl/deint_core.sv
module deint_core
    import deint_pkg::*;
#(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned WIDTH = 720
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_bypass,
    input  logic [PIX_W-1:0] cfg_motion_thr,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_up_y,
    input  logic [PIX_W-1:0] in_up_c,
    input  logic [PIX_W-1:0] in_dn_y,
    input  logic [PIX_W-1:0] in_dn_c,
    input  logic [PIX_W-1:0] in_prv_y,
    input  logic [PIX_W-1:0] in_prv_c,
    input  logic [PIX_W-1:0] in_nxt_y,
    input  logic [PIX_W-1:0] in_nxt_c,
    output logic             out_valid,
    output logic             out_sol,
    output logic             out_sof,
    output logic             out_moving,
    output logic [PIX_W-1:0] out_orig_y,
    output logic [PIX_W-1:0] out_orig_c,
    output logic [PIX_W-1:0] out_fill_y,
    output logic [PIX_W-1:0] out_fill_c
);

    seq_state_t seq_state;
    logic       seq_start, seq_shift, seq_emit, seq_flush;

    deint_seq #(.WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sol   (in_sol),
        .in_sof   (in_sof),
        .state_o  (seq_state),
        .start_o  (seq_start),
        .shift_o  (seq_shift),
        .emit_o   (seq_emit),
        .flush_o  (seq_flush)
    );

    // Pixel window: left and centre registered, right is the live beat
    logic [PIX_W-1:0] upy_l, upy_m, dny_l, dny_m;
    logic [PIX_W-1:0] upc_m, dnc_m, pvy_m, nxy_m, pvc_m, nxc_m;
    logic             first_m, sof_m, mode_byp;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upy_l <= '0; upy_m <= '0; dny_l <= '0; dny_m <= '0;
            upc_m <= '0; dnc_m <= '0; pvy_m <= '0; nxy_m <= '0;
            pvc_m <= '0; nxc_m <= '0;
            first_m <= 1'b0; sof_m <= 1'b0;
        end else if (seq_start || seq_shift) begin
            upy_l <= upy_m;    upy_m <= in_up_y;
            dny_l <= dny_m;    dny_m <= in_dn_y;
            upc_m <= in_up_c;  dnc_m <= in_dn_c;
            pvy_m <= in_prv_y; nxy_m <= in_nxt_y;
            pvc_m <= in_prv_c; nxc_m <= in_nxt_c;
            first_m <= seq_start;
            sof_m   <= seq_start && in_sof;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      mode_byp <= 1'b0;
        else if (seq_start && in_sof)    mode_byp <= cfg_bypass;
    end

    // Border replication
    logic [PIX_W-1:0] nb_up_l, nb_up_r, nb_dn_l, nb_dn_r;
    assign nb_up_l = first_m   ? upy_m : upy_l;
    assign nb_dn_l = first_m   ? dny_m : dny_l;
    assign nb_up_r = seq_flush ? upy_m : in_up_y;
    assign nb_dn_r = seq_flush ? dny_m : in_dn_y;

    logic [PIX_W-1:0] spat_y, fill_y, fill_c;
    logic             mv;
    dir_t             spat_dir;

    deint_dirsel #(.PIX_W(PIX_W)) u_dir (
        .up_l   (nb_up_l),
        .up_c   (upy_m),
        .up_r   (nb_up_r),
        .dn_l   (nb_dn_l),
        .dn_c   (dny_m),
        .dn_r   (nb_dn_r),
        .spat_o (spat_y),
        .dir_o  (spat_dir)
    );

    deint_blend #(.PIX_W(PIX_W)) u_blend (
        .bypass (mode_byp),
        .thr    (cfg_motion_thr),
        .spat_y (spat_y),
        .dn_y   (dny_m),
        .prv_y  (pvy_m),
        .nxt_y  (nxy_m),
        .up_c   (upc_m),
        .dn_c   (dnc_m),
        .prv_c  (pvc_m),
        .nxt_c  (nxc_m),
        .fill_y (fill_y),
        .fill_c (fill_c),
        .moving (mv)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sol    <= 1'b0;
            out_sof    <= 1'b0;
            out_moving <= 1'b0;
            out_orig_y <= '0;
            out_orig_c <= '0;
            out_fill_y <= '0;
            out_fill_c <= '0;
        end else begin
            out_valid <= seq_emit;
            if (seq_emit) begin
                out_sol    <= first_m;
                out_sof    <= sof_m;
                out_moving <= mv;
                out_orig_y <= upy_m;
                out_orig_c <= upc_m;
                out_fill_y <= fill_y;
                out_fill_c <= fill_c;
            end else begin
                out_sol <= 1'b0;
                out_sof <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/deint_core_chk.sv
module deint_core_chk
    import deint_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_sof,
    input seq_state_t state,
    input logic       start,
    input logic       bypass_q,
    input logic       out_valid,
    input logic       out_sol,
    input logic       out_sof
);

    assert_line_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINE && in_valid) |=> out_valid);

    assert_flush_emit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !out_valid);

    assert_gap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> !out_valid);

    assert_sof_has_sol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && in_sof) |=> $stable(bypass_q));

endmodule

bind deint_core deint_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .state     (seq_state),
    .start     (seq_start),
    .bypass_q  (mode_byp),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof)
);

// File: tb/deint_core_test.sv
`timescale 1ns/1ps
module deint_core_test;

    localparam int W  = 6;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_bypass = 1'b0;
    logic [PW-1:0] cfg_motion_thr = 8'd10;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [PW-1:0] in_up_y = '0, in_up_c = '0, in_dn_y = '0, in_dn_c = '0;
    logic [PW-1:0] in_prv_y = '0, in_prv_c = '0, in_nxt_y = '0, in_nxt_c = '0;
    logic          out_valid, out_sol, out_sof, out_moving;
    logic [PW-1:0] out_orig_y, out_orig_c, out_fill_y, out_fill_c;

    always #2 clk = ~clk;

    deint_core #(.PIX_W(PW), .WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_motion_thr(cfg_motion_thr),
        .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_up_y(in_up_y), .in_up_c(in_up_c), .in_dn_y(in_dn_y), .in_dn_c(in_dn_c),
        .in_prv_y(in_prv_y), .in_prv_c(in_prv_c), .in_nxt_y(in_nxt_y), .in_nxt_c(in_nxt_c),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_moving(out_moving),
        .out_orig_y(out_orig_y), .out_orig_c(out_orig_c),
        .out_fill_y(out_fill_y), .out_fill_c(out_fill_c)
    );

    int n_chk = 0;
    int n_fail = 0;

    int uy[W], dy[W], uc[W], dc[W], py[W], ny[W], pc[W], nc[W];

    // Output capture
    int cap_n = 0;
    int cap_oy[256], cap_oc[256], cap_fy[256], cap_fc[256];
    bit cap_mv[256], cap_sol[256], cap_sof[256];

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (cap_n < 256) begin
                cap_oy[cap_n]  = int'(out_orig_y);
                cap_oc[cap_n]  = int'(out_orig_c);
                cap_fy[cap_n]  = int'(out_fill_y);
                cap_fc[cap_n]  = int'(out_fill_c);
                cap_mv[cap_n]  = out_moving;
                cap_sol[cap_n] = out_sol;
                cap_sof[cap_n] = out_sof;
            end
            cap_n = cap_n + 1;
        end
    end

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rmean(input int a, input int b);
        return (a + b + 1) / 2;
    endfunction

    function automatic int adiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic ref_px(input int x, input bit byp, output int fy, output int fc, output int mv);
        int l, r, dv, dm, dp;
        l = (x == 0) ? x : x - 1;
        r = (x == W - 1) ? x : x + 1;
        mv = (!byp && adiff(py[x], ny[x]) > int'(cfg_motion_thr)) ? 1 : 0;
        if (byp) begin
            fy = dy[x]; fc = dc[x];
        end else if (mv == 0) begin
            fy = rmean(py[x], ny[x]); fc = rmean(pc[x], nc[x]);
        end else begin
            dv = adiff(uy[x], dy[x]);
            dm = adiff(uy[l], dy[r]);
            dp = adiff(uy[r], dy[l]);
            if (dv <= dm && dv <= dp) fy = rmean(uy[x], dy[x]);
            else if (dm <= dp)        fy = rmean(uy[l], dy[r]);
            else                      fy = rmean(uy[r], dy[l]);
            fc = rmean(uc[x], dc[x]);
        end
    endtask

    task automatic put_px(input int x, input bit sol, input bit sof);
        in_valid = 1'b1; in_sol = sol; in_sof = sof;
        in_up_y = PW'(uy[x]); in_up_c = PW'(uc[x]);
        in_dn_y = PW'(dy[x]); in_dn_c = PW'(dc[x]);
        in_prv_y = PW'(py[x]); in_prv_c = PW'(pc[x]);
        in_nxt_y = PW'(ny[x]); in_nxt_c = PW'(nc[x]);
    endtask

    task automatic idle_in();
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    endtask

    task automatic drive_line(input bit sof, input bit gap);
        for (int x = 0; x < W; x++) begin
            @(negedge clk);
            put_px(x, x == 0, (x == 0) && sof);
            if (gap) begin
                @(negedge clk);
                idle_in();
            end
        end
        @(negedge clk);
        idle_in();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_line(input int base, input bit byp, input bit sof_first);
        int fy, fc, mv, k;
        string rq;
        chk_eq("R9", "outputs per line", cap_n - base, W);
        for (int x = 0; x < W; x++) begin
            k = base + x;
            ref_px(x, byp, fy, fc, mv);
            if (byp) rq = "R8";
            else if (mv == 0) rq = "R3";
            else if (x == 0 || x == W - 1) rq = "R5";
            else rq = "R4";
            chk_eq("R7", $sformatf("orig luma x=%0d", x), cap_oy[k], uy[x]);
            chk_eq("R7", $sformatf("orig chroma x=%0d", x), cap_oc[k], uc[x]);
            chk_eq(rq, $sformatf("fill luma x=%0d", x), cap_fy[k], fy);
            chk_eq(byp ? "R8" : "R6", $sformatf("fill chroma x=%0d", x), cap_fc[k], fc);
            chk_eq(byp ? "R8" : "R2", $sformatf("moving x=%0d", x), int'(cap_mv[k]), mv);
            chk_eq("R10", $sformatf("sol x=%0d", x), int'(cap_sol[k]), (x == 0) ? 1 : 0);
            chk_eq("R10", $sformatf("sof x=%0d", x), int'(cap_sof[k]), (x == 0 && sof_first) ? 1 : 0);
        end
    endtask

    task automatic pat_static();
        cfg_motion_thr = 8'd10;
        for (int x = 0; x < W; x++) begin
            uy[x] = 200 - 30 * x; dy[x] = 25 * x;
            uc[x] = 128 + x;      dc[x] = 100 + 2 * x;
            py[x] = 40 + 20 * x;  ny[x] = py[x] + ((x % 2 == 0) ? 10 : 3);
            pc[x] = 60 + 5 * x;   nc[x] = 90 - 3 * x;
        end
    endtask

    task automatic pat_moving_edge();
        for (int x = 0; x < W; x++) begin
            uy[x] = (x < 3) ? 20 : 220; dy[x] = (x < 2) ? 20 : 220;
            uc[x] = 50 + 9 * x;         dc[x] = 180 - 7 * x;
            py[x] = 0;                  ny[x] = 200;
            pc[x] = 10;                 nc[x] = 30;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_eq("R1", "out_valid after reset", int'(out_valid), 0);
        chk_eq("R10", "out_sof after reset", int'(out_sof), 0);
    endtask

    task automatic t_idle_ignored();
        int base;
        pat_static();
        base = cap_n;
        drive_line(1'b0, 1'b0);   // line-start only, no frame-start
        chk_eq("R1", "outputs before frame start", cap_n - base, 0);
    endtask

    task automatic t_static_weave();
        int base;
        pat_static();
        base = cap_n;
        drive_line(1'b1, 1'b0);
        check_line(base, 1'b0, 1'b1);   // R3 and R2 boundary at diff == thr
    endtask

    task automatic t_moving_edge();
        int base;
        pat_moving_edge();
        base = cap_n;
        drive_line(1'b0, 1'b0);
        check_line(base, 1'b0, 1'b0);   // R4 diagonal edge, R6 chroma
    endtask

    task automatic t_threshold();
        int base;
        cfg_motion_thr = 8'd10;
        for (int x = 0; x < W; x++) begin
            uy[x] = 30 + 10 * x; dy[x] = 90 - 5 * x;
            uc[x] = 70; dc[x] = 75;
            py[x] = 100;
            ny[x] = (x == W - 1) ? 89 : ((x % 2 == 0) ? 110 : 111);
            pc[x] = 20; nc[x] = 41;
        end
        base = cap_n;
        drive_line(1'b0, 1'b0);
        check_line(base, 1'b0, 1'b0);   // R2 equal vs one above
        chk_eq("R2", "x=0 diff equals thr is static", int'(cap_mv[base]), 0);
        chk_eq("R2", "x=1 diff above thr is moving", int'(cap_mv[base + 1]), 1);
    endtask

    task automatic t_ties();
        int base;
        for (int x = 0; x < W; x++) begin
            uy[x] = (x % 2 == 0) ? 100 : 0;
            dy[x] = (x % 2 == 0) ? 0 : 100;
            uc[x] = 10 * x; dc[x] = 200 - 10 * x;
            py[x] = 0; ny[x] = 255; pc[x] = 0; nc[x] = 0;
        end
        base = cap_n;
        drive_line(1'b0, 1'b0);
        check_line(base, 1'b0, 1'b0);   // R4 tie rules
    endtask

    task automatic t_border();
        int base;
        for (int x = 0; x < W; x++) begin
            uy[x] = 40 * x; dy[x] = 240 - 40 * x;
            uc[x] = 5; dc[x] = 250; py[x] = 255; ny[x] = 0; pc[x] = 1; nc[x] = 2;
        end
        base = cap_n;
        drive_line(1'b0, 1'b0);
        check_line(base, 1'b0, 1'b0);
        // R5 left border: x-1 replaced by x, tie between diagonals goes negative
        chk_eq("R5", "left border fill", cap_fy[base], rmean(uy[0], dy[1]));
    endtask

    task automatic t_bypass_latch();
        int base;
        pat_moving_edge();
        cfg_bypass = 1'b1;
        base = cap_n;
        drive_line(1'b1, 1'b0);
        check_line(base, 1'b1, 1'b1);
        cfg_bypass = 1'b0;             // mid-frame change: no effect
        base = cap_n;
        drive_line(1'b0, 1'b0);
        check_line(base, 1'b1, 1'b0);  // R8
        base = cap_n;
        drive_line(1'b1, 1'b0);        // new frame picks up the change
        check_line(base, 1'b0, 1'b1);
    endtask

    task automatic t_gap_ignored();
        int base;
        pat_static();
        base = cap_n;
        for (int x = 0; x < 3; x++) begin
            @(negedge clk);
            put_px(x, 1'b0, 1'b0);
        end
        @(negedge clk);
        idle_in();
        repeat (3) @(negedge clk);
        chk_eq("R11", "outputs from untagged pixels between lines", cap_n - base, 0);
        base = cap_n;
        drive_line(1'b0, 1'b1);        // gapped input still yields the full line
        check_line(base, 1'b0, 1'b0);
    endtask

    task automatic t_latency();
        int base;
        pat_static();
        base = cap_n;
        @(negedge clk);
        put_px(0, 1'b1, 1'b1);
        @(negedge clk);
        idle_in();
        chk_eq("R9", "no output after first pixel alone", int'(out_valid), 0);
        for (int x = 1; x < W; x++) begin
            @(negedge clk);
            put_px(x, 1'b0, 1'b0);
            @(negedge clk);
            idle_in();
            chk_eq("R9", $sformatf("output after accept of x=%0d", x), int'(out_valid), 1);
            chk_eq("R9", $sformatf("output pixel for x=%0d", x - 1), int'(out_orig_y), uy[x - 1]);
            @(negedge clk);
            if (x == W - 1) begin
                chk_eq("R9", "last pixel without further input", int'(out_valid), 1);
                chk_eq("R9", "last pixel value", int'(out_orig_y), uy[W - 1]);
                @(negedge clk);
            end
            chk_eq("R9", $sformatf("quiet while waiting x=%0d", x), int'(out_valid), 0);
        end
        chk_eq("R9", "latency line count", cap_n - base, W);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_ignored();
        t_static_weave();
        t_moving_edge();
        t_threshold();
        t_ties();
        t_border();
        t_bypass_latch();
        t_gap_ignored();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule